// File: doc/BRIEF.md
# Processor exception entry and return unit

This block performs the register work that a 32-bit processor does when it takes an exception and when it comes back from one. When an event is accepted, it saves the current program counter, status word and general register 15 into three shadow registers. It computes the new status word and stores the 12-bit event code in the right event register. It then emits a one-cycle redirect strobe together with the address where fetch must resume.

A return-from-exception request sends fetch back to the saved program counter and hands back the saved status word. The saved copy of general register 15 is left as it is. The pipeline around the block supplies the current architectural values and the event details, and it applies the new status word when the strobe fires. A small register port gives software read and write access to the vector base and the three shadow registers, and read access to both event registers.

Top module: `exc_entry_unit`

## Requirements
- R1: When `take_i` is high at a clock edge, the saved-PC, saved-SR and saved-R15 registers all load `pc_i`, `sr_i` and `r15_i` at that same edge.
- R2: On entry, `sr_out_o` equals `sr_i` with bits 30 (privileged mode), 29 (register bank) and 28 (block) forced to 1. Every other bit keeps its value, except bit 15 as R3 states.
- R3: Bit 15 of `sr_out_o` (FPU disable) is cleared on entry only when `kind_i` is 2'b00 (reset). For kinds 2'b01 and 2'b11 (general exception) and 2'b10 (interrupt), bit 15 is copied from `sr_i`.
- R4: On entry, `code_i` is written to the low 12 bits of the exception event register (address 4) when the kind is reset or general exception, and to the interrupt event register (address 5) when the kind is interrupt. The other event register keeps its value, and bits 31:12 of both always read 0.
- R5: For a reset-kind entry, `target_o` is 32'hA000_0000.
- R6: For any other kind, `target_o` is the vector base register value plus `offset_i`, modulo 2^32. For example, base 32'h9C08_0000 with offset 32'h400 gives 32'h9C08_0400.
- R7: When `rte_i` is high and `take_i` is low, `target_o` becomes the saved PC and `sr_out_o` becomes the saved SR. The saved-R15 register is not changed.
- R8: `redirect_o` is high for exactly the one cycle after each edge at which `take_i` or `rte_i` was high, and low otherwise. When both are high at the same edge, the entry is performed and the return is dropped.
- R9: Register port map for `reg_addr_i`: 0 is the vector base, 1 saved PC, 2 saved SR, 3 saved R15, 4 exception event, 5 interrupt event, and 6 and 7 read 0. `reg_rdata_o` shows the addressed register combinationally. A write with `reg_we_i` to addresses 0 to 3 takes effect at the clock edge. Writes to addresses 4 to 7 are ignored, and every write made at an edge where `take_i` is high is ignored.
- R10: While `rst_n` is low, all registers clear to 0 (the vector base included) and `redirect_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Accept an event this cycle |
| kind_i | input | 2 | Event kind: 00 reset, 01/11 general exception, 10 interrupt |
| code_i | input | 12 | Event code to record |
| offset_i | input | 32 | Vector offset added to the base for non-reset events |
| pc_i | input | 32 | Current program counter |
| sr_i | input | 32 | Current status word |
| r15_i | input | 32 | Current general register 15 |
| rte_i | input | 1 | Return-from-exception request |
| reg_we_i | input | 1 | Register port write enable |
| reg_addr_i | input | 3 | Register port address |
| reg_wdata_i | input | 32 | Register port write data |
| reg_rdata_o | output | 32 | Register port read data |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| target_o | output | 32 | Address where fetch resumes |
| sr_out_o | output | 32 | Status word to install with the redirect |

## Verification
On every cycle, the embedded properties check five things. The three shadow registers must track the inputs at entry. The forced status bits and the FPU-disable clearing on reset must hold. The fixed reset target and the redirect timing must be correct. A return must use the saved PC and leave the saved R15 untouched, and the vector base must not move during an entry. The vector base sum with its wraparound, the choice of event register and the zeroed upper event bits are shown only by the bench's sweeps, which cover every event kind against a range of status and base patterns. The same holds for the register port map, the writes that must be ignored, and the outcome when an entry and a return collide.

// File: rtl/exc_entry_unit.sv
module exc_entry_unit #(
  parameter logic [31:0] RESET_VECTOR = 32'hA000_0000,
  parameter int          BL_BIT       = 28,
  parameter int          RB_BIT       = 29,
  parameter int          MD_BIT       = 30,
  parameter int          FD_BIT       = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take_i,
  input  logic [1:0]  kind_i,
  input  logic [11:0] code_i,
  input  logic [31:0] offset_i,
  input  logic [31:0] pc_i,
  input  logic [31:0] sr_i,
  input  logic [31:0] r15_i,
  input  logic        rte_i,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        redirect_o,
  output logic [31:0] target_o,
  output logic [31:0] sr_out_o
);

  localparam logic [1:0] KIND_RESET = 2'b00;
  localparam logic [1:0] KIND_INTR  = 2'b10;

  logic [31:0] vbr_q, spc_q, ssr_q, sgr_q;
  logic [11:0] exp_code_q, int_code_q;
  logic [31:0] entry_sr;
  logic        is_rst;

  assign is_rst = (kind_i == KIND_RESET);

  always_comb begin
    entry_sr         = sr_i;
    entry_sr[BL_BIT] = 1'b1;
    entry_sr[RB_BIT] = 1'b1;
    entry_sr[MD_BIT] = 1'b1;
    if (is_rst) entry_sr[FD_BIT] = 1'b0;
  end

  always_comb begin
    case (reg_addr_i)
      3'd0:    reg_rdata_o = vbr_q;
      3'd1:    reg_rdata_o = spc_q;
      3'd2:    reg_rdata_o = ssr_q;
      3'd3:    reg_rdata_o = sgr_q;
      3'd4:    reg_rdata_o = {20'd0, exp_code_q};
      3'd5:    reg_rdata_o = {20'd0, int_code_q};
      default: reg_rdata_o = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vbr_q      <= '0;
      spc_q      <= '0;
      ssr_q      <= '0;
      sgr_q      <= '0;
      exp_code_q <= '0;
      int_code_q <= '0;
      redirect_o <= 1'b0;
      target_o   <= '0;
      sr_out_o   <= '0;
    end else begin
      redirect_o <= take_i | rte_i;
      if (take_i) begin
        spc_q    <= pc_i;
        ssr_q    <= sr_i;
        sgr_q    <= r15_i;
        sr_out_o <= entry_sr;
        target_o <= is_rst ? RESET_VECTOR : vbr_q + offset_i;
        if (kind_i == KIND_INTR) int_code_q <= code_i;
        else                     exp_code_q <= code_i;
      end else begin
        if (rte_i) begin
          target_o <= spc_q;
          sr_out_o <= ssr_q;
        end
        if (reg_we_i) begin
          case (reg_addr_i)
            3'd0:    vbr_q <= reg_wdata_i;
            3'd1:    spc_q <= reg_wdata_i;
            3'd2:    ssr_q <= reg_wdata_i;
            3'd3:    sgr_q <= reg_wdata_i;
            default: ;
          endcase
        end
      end
    end
  end

  // R1
  save_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take_i) |-> (spc_q == $past(pc_i) && ssr_q == $past(sr_i) && sgr_q == $past(r15_i)));

  // R2
  forced_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take_i) |-> (sr_out_o[MD_BIT] && sr_out_o[RB_BIT] && sr_out_o[BL_BIT]));

  // R3
  fd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take_i && kind_i == KIND_RESET) |-> !sr_out_o[FD_BIT]);

  // R5
  reset_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take_i && kind_i == KIND_RESET) |-> target_o == RESET_VECTOR);

  // R7
  rte_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rte_i && !take_i) |-> (target_o == $past(spc_q) && sr_out_o == $past(ssr_q)));

  // R7
  sgr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rte_i && !take_i && !(reg_we_i && reg_addr_i == 3'd3)) |-> $stable(sgr_q));

  // R8
  strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o == $past(take_i || rte_i));

  // R9
  vbr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take_i) |-> $stable(vbr_q));

endmodule

// File: tb/exc_entry_unit_test.sv
`timescale 1ns/1ps
module exc_entry_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        take_i = 1'b0;
  logic [1:0]  kind_i = 2'b00;
  logic [11:0] code_i = '0;
  logic [31:0] offset_i = '0, pc_i = '0, sr_i = '0, r15_i = '0;
  logic        rte_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o, target_o, sr_out_o;
  logic        redirect_o;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  exc_entry_unit uut (
    .clk(clk), .rst_n(rst_n), .take_i(take_i), .kind_i(kind_i), .code_i(code_i),
    .offset_i(offset_i), .pc_i(pc_i), .sr_i(sr_i), .r15_i(r15_i), .rte_i(rte_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .redirect_o(redirect_o), .target_o(target_o),
    .sr_out_o(sr_out_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  logic [31:0] exp_vbr, exp_spc, exp_ssr, exp_sgr, exp_sr, d;
  logic [11:0] exp_evt, exp_iev;

  initial begin
    repeat (1000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 redirect", {31'd0, redirect_o}, 32'd0);
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d);
      chk("R10 reg", d, 32'd0);
    end
    rst_n = 1'b1;
    exp_evt = '0; exp_iev = '0;
    @(negedge clk);
    chk("R8 idle", {31'd0, redirect_o}, 32'd0);

    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 8; i++) begin
        exp_vbr = (i == 7) ? 32'hFFFF_FC00 : 32'h9C08_0000 + i * 32'h0110_0000;
        wr(3'd0, exp_vbr);
        rd(3'd0, d);
        chk("R9 vbr write", d, exp_vbr);
        @(negedge clk);
        take_i = 1'b1; kind_i = k[1:0];
        code_i = 12'h040 + k * 12'h100 + i[11:0];
        offset_i = (i == 3) ? 32'h400 : 32'h100 * (i + 1) + k * 32'h20;
        pc_i = 32'h8C00_1000 + i * 32'h44 + k;
        sr_i = (32'h1234_5678 ^ (i * 32'h0101_8421)) ^ (k[0] ? 32'h7000_8000 : 32'h0);
        r15_i = 32'hAC00_0F00 - i * 4 - k;
        // colliding write is ignored
        reg_we_i = 1'b1; reg_addr_i = 3'd0; reg_wdata_i = 32'hDEAD_BEEF;
        @(negedge clk);
        take_i = 1'b0; reg_we_i = 1'b0;
        exp_sr = sr_i | 32'h7000_0000;
        if (k == 0) exp_sr[15] = 1'b0;
        if (k == 2) exp_iev = code_i; else exp_evt = code_i;
        chk("R8 strobe", {31'd0, redirect_o}, 32'd1);
        chk("R2 R3 sr", sr_out_o, exp_sr);
        chk(k == 0 ? "R5 target" : "R6 target", target_o, k == 0 ? 32'hA000_0000 : exp_vbr + offset_i);
        rd(3'd1, d); chk("R1 spc", d, pc_i);
        rd(3'd2, d); chk("R1 ssr", d, sr_i);
        rd(3'd3, d); chk("R1 sgr", d, r15_i);
        rd(3'd4, d); chk("R4 expevt", d, {20'd0, exp_evt});
        rd(3'd5, d); chk("R4 intevt", d, {20'd0, exp_iev});
        rd(3'd0, d); chk("R9 write during entry", d, exp_vbr);
        @(negedge clk);
        chk("R8 one cycle", {31'd0, redirect_o}, 32'd0);
      end
    end

    // R9 read-only and unused addresses
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd4, d); chk("R9 expevt ro", d, {20'd0, exp_evt});
    rd(3'd5, d); chk("R9 intevt ro", d, {20'd0, exp_iev});
    rd(3'd6, d); chk("R9 unused", d, 32'd0);
    rd(3'd7, d); chk("R9 unused", d, 32'd0);

    // R7 return uses shadows, keeps saved R15
    for (int i = 0; i < 4; i++) begin
      exp_spc = 32'h8000_2000 + i * 32'h10;
      exp_ssr = 32'h4000_00F0 ^ (i * 32'h1111);
      exp_sgr = 32'h5555_0000 + i;
      wr(3'd1, exp_spc); wr(3'd2, exp_ssr); wr(3'd3, exp_sgr);
      @(negedge clk);
      rte_i = 1'b1; r15_i = 32'h0BAD_0000 + i;
      @(negedge clk);
      rte_i = 1'b0;
      chk("R8 rte strobe", {31'd0, redirect_o}, 32'd1);
      chk("R7 target", target_o, exp_spc);
      chk("R7 sr", sr_out_o, exp_ssr);
      rd(3'd3, d); chk("R7 sgr kept", d, exp_sgr);
      @(negedge clk);
      chk("R8 rte one cycle", {31'd0, redirect_o}, 32'd0);
    end

    // R8 entry wins over simultaneous return
    wr(3'd0, 32'h9C08_0000);
    wr(3'd1, 32'h1111_1111);
    @(negedge clk);
    take_i = 1'b1; rte_i = 1'b1; kind_i = 2'b01; offset_i = 32'h400;
    pc_i = 32'h2222_2222; sr_i = 32'h0000_8001; code_i = 12'h3E0;
    @(negedge clk);
    take_i = 1'b0; rte_i = 1'b0;
    chk("R8 collision target", target_o, 32'h9C08_0400);
    chk("R8 collision sr", sr_out_o, 32'h7000_8001);
    rd(3'd1, d); chk("R8 collision spc", d, 32'h2222_2222);
    @(negedge clk);
    chk("R8 collision strobe", {31'd0, redirect_o}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule